// File: doc/BRIEF.md
# Stack Pointer Unit with Selectable 8/11-bit Range

This block keeps the stack pointer for an 8-bit microcontroller core and turns each stack request from the core into an internal RAM address. A configuration flag selects the range. With the flag clear the pointer is a single byte and wraps inside 256 locations. With the flag set the pointer grows to 11 bits, and a high-byte register supplies the three upper address bits. Software reaches the pointer low byte, the pointer high byte and the configuration register through a byte-wide special-function-register (SFR) port. The read side of that port is combinational on the address.

The core issues four kinds of request: push, pop, call and return. A push or call increments the pointer first and then writes at the new value. A pop or return reads at the current value and decrements afterwards. Call and return move two bytes over two consecutive cycles and accept no new request during their second cycle. Every byte access updates the pointer once. The RAM and the instruction decoding are outside the block.

Top module: `spUnit`

## Requirements
- R1: After reset the low pointer byte (SFR 81H) reads 07H, the high pointer byte (SFR B7H) reads 00H and the configuration register (SFR AFH) reads 00H, so extended mode is off.
- R2: A push (opKind=0) drives ramWr=1 and ramByteHigh=0 in the cycle it is accepted, with ramAddr equal to the pointer plus one, and the pointer takes that value at the clock edge. The first push after reset writes address 08H.
- R3: A pop (opKind=1) drives ramRd=1 and ramByteHigh=0 with ramAddr equal to the current pointer, and the pointer is decremented at the clock edge.
- R4: A call (opKind=2) writes the low return byte at pointer+1 (ramByteHigh=0) in its first cycle and the high return byte at pointer+2 (ramByteHigh=1) in the next cycle. ramWr and ramRd are never high together.
- R5: A return (opKind=3) reads the high byte at the pointer (ramByteHigh=1) in its first cycle and the low byte at pointer-1 (ramByteHigh=0) in the next cycle. The pointer ends two below its starting value.
- R6: With extended mode off, incrementing from FFH gives 00H, decrementing from 00H gives FFH, and ramAddr bits 10..8 stay zero.
- R7: With extended mode on, incrementing from 0FFH gives 100H, incrementing from 7FFH gives 000H, and decrementing from 000H gives 7FFH.
- R8: In extended mode the high-byte SFR holds pointer bits 10..8 in its bits 2..0 and reads zero in bits 7..3. With extended mode off it reads 00H, and writes to it leave the pointer unchanged.
- R9: Configuration bit 7 selects extended mode and bit 0 is a stored flag. Bits 6..1 always read zero.
- R10: An SFR write to the low or high pointer byte in the same cycle as a stack access sets the pointer to the written value and discards that access's pointer update. The access itself still uses the address it had before the write.
- R11: Clearing extended mode while pointer bits 10..8 are nonzero clears them, so the next access uses an address below 100H.
- R12: opReady is low during the second cycle of a call or return, and a request presented in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Stack request present |
| opKind | input | 2 | 0 push, 1 pop, 2 call, 3 return |
| opReady | output | 1 | Request accepted this cycle when high |
| sfrAddr | input | 8 | SFR address for read and write |
| sfrWrEn | input | 1 | SFR write strobe |
| sfrWrData | input | 8 | SFR write data |
| sfrRdData | output | 8 | SFR read data for sfrAddr; 00H for unmapped addresses |
| ramAddr | output | 11 | Internal RAM address of the current stack access |
| ramWr | output | 1 | Stack write this cycle |
| ramRd | output | 1 | Stack read this cycle |
| ramByteHigh | output | 1 | Current call or return byte is the high return byte |

## Verification
Single pushes and pops run from the reset value, which separates increment-before-write from read-then-decrement. Back-to-back call and return sequences, with a request held high during the busy cycle, show the byte order and that the second request is ignored. Pointers preloaded at FFH, 0FFH and 7FFH are pushed and popped in both modes, so an 8-bit wrap cannot be mistaken for an 11-bit carry. SFR writes that land together with stack accesses, high-byte writes with the mode off, and a mode switch with nonzero upper bits check write priority and the upper-bit clearing.

// File: rtl/spPkg.sv
package spPkg;

  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } stackOpE;

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic inc;     // pre-increment, address is the incremented pointer
    logic dec;     // post-decrement, address is the current pointer
    logic wr;      // RAM write this cycle
    logic rd;      // RAM read this cycle
    logic hiByte;  // byte is the high half of a return address
  } spStrobeS;

endpackage

// File: rtl/spControl.sv
module spControl
  import spPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     opValid,
  input  stackOpE  opKind,
  output logic     opReady,
  output spStrobeS strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_CALL_HI, ST_RET_LO} ctlStateE;

  ctlStateE stateQ, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = stateQ;
    opReady   = (stateQ == ST_IDLE);
    case (stateQ)
      ST_IDLE: begin
        if (opValid) begin
          case (opKind)
            OP_PUSH: begin
              strobe.inc = 1'b1;
              strobe.wr  = 1'b1;
            end
            OP_POP: begin
              strobe.dec = 1'b1;
              strobe.rd  = 1'b1;
            end
            OP_CALL: begin
              strobe.inc = 1'b1;
              strobe.wr  = 1'b1;
              stateNext  = ST_CALL_HI;
            end
            default: begin
              strobe.dec    = 1'b1;
              strobe.rd     = 1'b1;
              strobe.hiByte = 1'b1;
              stateNext     = ST_RET_LO;
            end
          endcase
        end
      end
      ST_CALL_HI: begin
        strobe.inc    = 1'b1;
        strobe.wr     = 1'b1;
        strobe.hiByte = 1'b1;
        stateNext     = ST_IDLE;
      end
      ST_RET_LO: begin
        strobe.dec = 1'b1;
        strobe.rd  = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  // R4: an accepted call is followed by the high-byte write
  assert_call_second_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opReady && opValid && opKind == OP_CALL) |=> (strobe.wr && strobe.hiByte && !opReady));

  // R5: an accepted return is followed by the low-byte read
  assert_ret_second_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opReady && opValid && opKind == OP_RET) |=> (strobe.rd && !strobe.hiByte && !opReady));

  // R12: the busy window lasts exactly one cycle
  assert_busy_one_R12: assert property (@(posedge clk) disable iff (!rstN)
    !opReady |=> opReady);

endmodule

// File: rtl/spDatapath.sv
module spDatapath
  import spPkg::*;
#(
  parameter int         PTR_W    = 11,     // 9..16
  parameter logic [7:0] SPL_ADDR = 8'h81,
  parameter logic [7:0] SPH_ADDR = 8'hB7,
  parameter logic [7:0] CFG_ADDR = 8'hAF,
  parameter logic [7:0] RESET_SP = 8'h07
) (
  input  logic             clk,
  input  logic             rstN,
  input  spStrobeS         strobe,
  input  logic [7:0]       sfrAddr,
  input  logic             sfrWrEn,
  input  logic [7:0]       sfrWrData,
  output logic [7:0]       sfrRdData,
  output logic [PTR_W-1:0] ramAddr,
  output logic             ramWr,
  output logic             ramRd,
  output logic             ramByteHigh
);

  localparam int HI_W = PTR_W - 8;
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);
  localparam logic [HI_W-1:0]  HI_ZERO = '0;

  logic [PTR_W-1:0] spQ, spNext, spInc, spDec, opNext, ptrBase;
  logic             extQ, xenQ, extNext;
  logic             splWr, sphWr, cfgWr;

  // Wrap rules: full-width arithmetic in extended mode, byte arithmetic otherwise
  always_comb begin
    if (extQ) begin
      spInc = spQ + ONE;
      spDec = spQ - ONE;
    end else begin
      spInc = {HI_ZERO, spQ[7:0] + 8'd1};
      spDec = {HI_ZERO, spQ[7:0] - 8'd1};
    end
  end

  assign splWr = sfrWrEn && (sfrAddr == SPL_ADDR);
  assign sphWr = sfrWrEn && (sfrAddr == SPH_ADDR) && extQ;
  assign cfgWr = sfrWrEn && (sfrAddr == CFG_ADDR);

  always_comb begin
    if (strobe.inc)      opNext = spInc;
    else if (strobe.dec) opNext = spDec;
    else                 opNext = spQ;

    // direct pointer writes win over the stack update
    if (splWr)      ptrBase = {spQ[PTR_W-1:8], sfrWrData};
    else if (sphWr) ptrBase = {sfrWrData[HI_W-1:0], spQ[7:0]};
    else            ptrBase = opNext;

    extNext = cfgWr ? sfrWrData[7] : extQ;
    spNext  = extNext ? ptrBase : {HI_ZERO, ptrBase[7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spQ  <= {HI_ZERO, RESET_SP};
      extQ <= 1'b0;
      xenQ <= 1'b0;
    end else begin
      spQ  <= spNext;
      extQ <= extNext;
      if (cfgWr) xenQ <= sfrWrData[0];
    end
  end

  assign ramAddr     = strobe.inc ? spInc : spQ;
  assign ramWr       = strobe.wr;
  assign ramRd       = strobe.rd;
  assign ramByteHigh = strobe.hiByte;

  always_comb begin
    if (sfrAddr == SPL_ADDR)      sfrRdData = spQ[7:0];
    else if (sfrAddr == SPH_ADDR) sfrRdData = extQ ? {{(8-HI_W){1'b0}}, spQ[PTR_W-1:8]} : 8'h00;
    else if (sfrAddr == CFG_ADDR) sfrRdData = {extQ, 6'b0, xenQ};
    else                          sfrRdData = 8'h00;
  end

  // R2: a push without a pointer write advances the low byte by one
  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && !splWr && !sphWr) |=> (spQ[7:0] == $past(spQ[7:0]) + 8'd1));

  // R3: a pop without a pointer write retreats the low byte by one
  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !splWr && !sphWr) |=> (spQ[7:0] == $past(spQ[7:0]) - 8'd1));

  // R4: never read and write in one cycle
  assert_rw_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wr && strobe.rd));

  // R11: upper bits are zero whenever extended mode is off
  assert_upper_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    !extQ |-> (spQ[PTR_W-1:8] == HI_ZERO));

  // R8: a high-byte write in narrow mode changes nothing
  assert_sph_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sfrWrEn && sfrAddr == SPH_ADDR && !extQ && !strobe.inc && !strobe.dec) |=> $stable(spQ));

  // R10: a low-byte write lands regardless of a concurrent access
  assert_spl_priority_R10: assert property (@(posedge clk) disable iff (!rstN)
    splWr |=> (spQ[7:0] == $past(sfrWrData)));

endmodule

// File: rtl/spUnit.sv
module spUnit
  import spPkg::*;
#(
  parameter int PTR_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [1:0]       opKind,
  output logic             opReady,
  input  logic [7:0]       sfrAddr,
  input  logic             sfrWrEn,
  input  logic [7:0]       sfrWrData,
  output logic [7:0]       sfrRdData,
  output logic [PTR_W-1:0] ramAddr,
  output logic             ramWr,
  output logic             ramRd,
  output logic             ramByteHigh
);

  spStrobeS strobe;

  spControl ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opKind  (stackOpE'(opKind)),
    .opReady (opReady),
    .strobe  (strobe)
  );

  spDatapath #(.PTR_W(PTR_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .sfrAddr     (sfrAddr),
    .sfrWrEn     (sfrWrEn),
    .sfrWrData   (sfrWrData),
    .sfrRdData   (sfrRdData),
    .ramAddr     (ramAddr),
    .ramWr       (ramWr),
    .ramRd       (ramRd),
    .ramByteHigh (ramByteHigh)
  );

endmodule

// File: tb/spUnit_tb_top.sv
module spUnit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opKind = 2'd0;
  logic        opReady;
  logic [7:0]  sfrAddr = 8'h00;
  logic        sfrWrEn = 1'b0;
  logic [7:0]  sfrWrData = 8'h00;
  logic [7:0]  sfrRdData;
  logic [10:0] ramAddr;
  logic        ramWr, ramRd, ramByteHigh;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  int mSp = 7, mExt = 0, mXen = 0, mPhase = 0;

  always #5 clk = ~clk;

  spUnit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .opReady(opReady),
    .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn), .sfrWrData(sfrWrData), .sfrRdData(sfrRdData),
    .ramAddr(ramAddr), .ramWr(ramWr), .ramRd(ramRd), .ramByteHigh(ramByteHigh)
  );

  localparam logic [7:0] A_SPL = 8'h81, A_SPH = 8'hB7, A_CFG = 8'hAF;

  task automatic step(input logic v, input logic [1:0] k, input logic we,
                      input logic [7:0] a, input logic [7:0] d, input string tag);
    int mask, eAddr, eRd8, nSp, nExt, nXen, nPhase;
    bit inc, dec, hi, eReady;
    logic [22:0] got, exp;
    @(negedge clk);
    opValid = v; opKind = k; sfrWrEn = we; sfrAddr = a; sfrWrData = d;
    #2;
    mask = (mExt != 0) ? 2047 : 255;
    eReady = (mPhase == 0);
    inc = 0; dec = 0; hi = 0; nPhase = 0;
    if (mPhase == 1) begin inc = 1; hi = 1; end
    else if (mPhase == 2) dec = 1;
    else if (v) begin
      case (k)
        2'd0: inc = 1;
        2'd1: dec = 1;
        2'd2: begin inc = 1; nPhase = 1; end
        default: begin dec = 1; hi = 1; nPhase = 2; end
      endcase
    end
    eAddr = inc ? ((mSp + 1) & mask) : mSp;
    if (a == A_SPL)      eRd8 = mSp & 255;
    else if (a == A_SPH) eRd8 = (mExt != 0) ? ((mSp >> 8) & 7) : 0;
    else if (a == A_CFG) eRd8 = (mExt << 7) | mXen;
    else                 eRd8 = 0;
    exp = {11'(eAddr), inc, dec, hi, eReady, 8'(eRd8)};
    got = {ramAddr, ramWr, ramRd, ramByteHigh, opReady, sfrRdData};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got addr=%h wr=%b rd=%b hi=%b rdy=%b rdata=%h exp addr=%h wr=%b rd=%b hi=%b rdy=%b rdata=%h",
               tag, ramAddr, ramWr, ramRd, ramByteHigh, opReady, sfrRdData,
               eAddr, inc, dec, hi, eReady, eRd8);
    end
    nSp = inc ? ((mSp + 1) & mask) : (dec ? ((mSp - 1) & mask) : mSp);
    nExt = mExt; nXen = mXen;
    if (we) begin
      if (a == A_SPL) nSp = (mSp & ~255) | int'(d);
      else if (a == A_SPH && mExt != 0) nSp = (mSp & 255) | ((int'(d) & 7) << 8);
      else if (a == A_CFG) begin nExt = int'(d[7]); nXen = int'(d[0]); end
    end
    if (nExt == 0) nSp = nSp & 255;
    @(posedge clk);
    mSp = nSp; mExt = nExt; mXen = nXen; mPhase = nPhase;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1'b0, 2'd0, 1'b0, a, 8'h00, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    step(1'b0, 2'd0, 1'b1, a, d, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    rd(A_SPL, "R1 reset low byte");
    rd(A_SPH, "R1 reset high byte");
    rd(A_CFG, "R1 reset config");
    step(1'b1, 2'd0, 1'b0, A_SPL, 8'h00, "R2 first push at 08H");
    rd(A_SPL, "R2 pointer after push");
    step(1'b1, 2'd0, 1'b0, A_SPL, 8'h00, "R2 second push");
    step(1'b1, 2'd1, 1'b0, A_SPL, 8'h00, "R3 pop");
    step(1'b1, 2'd1, 1'b0, A_SPL, 8'h00, "R3 pop again");
    rd(A_SPL, "R3 pointer after pops");
    step(1'b1, 2'd2, 1'b0, A_SPL, 8'h00, "R4 call low byte");
    step(1'b1, 2'd0, 1'b0, A_SPL, 8'h00, "R12 push during call busy");
    rd(A_SPL, "R12 pointer after call");
    step(1'b1, 2'd3, 1'b0, A_SPL, 8'h00, "R5 return high byte");
    step(1'b1, 2'd1, 1'b0, A_SPL, 8'h00, "R12 pop during return busy");
    rd(A_SPL, "R5 pointer after return");
    step(1'b1, 2'd2, 1'b0, A_SPL, 8'h00, "R4 back-to-back call");
    step(1'b0, 2'd0, 1'b0, A_SPL, 8'h00, "R4 call high byte");
    step(1'b1, 2'd2, 1'b0, A_SPL, 8'h00, "R4 second call");
    step(1'b0, 2'd0, 1'b0, A_SPL, 8'h00, "R4 second call high");
    step(1'b1, 2'd3, 1'b0, A_SPL, 8'h00, "R5 return");
    step(1'b0, 2'd0, 1'b0, A_SPL, 8'h00, "R5 return low");
    wr(A_SPL, 8'hFF, "R6 preload FF");
    step(1'b1, 2'd0, 1'b0, A_SPL, 8'h00, "R6 push wraps to 00");
    step(1'b1, 2'd1, 1'b0, A_SPL, 8'h00, "R6 pop at 00");
    rd(A_SPL, "R6 pointer wrapped to FF");
    wr(A_SPH, 8'h05, "R8 high write ignored narrow");
    rd(A_SPH, "R8 high reads 00 narrow");
    rd(A_SPL, "R8 low unchanged");
    step(1'b1, 2'd0, 1'b0, A_SPH, 8'h00, "R8 address stays narrow");
    wr(A_CFG, 8'h7F, "R9 config reserved bits");
    rd(A_CFG, "R9 config reads 01");
    wr(A_CFG, 8'h81, "R9 config ext on");
    rd(A_CFG, "R9 config reads 81");
    wr(A_SPL, 8'hFF, "R7 preload low");
    wr(A_SPH, 8'h00, "R7 preload high");
    step(1'b1, 2'd0, 1'b0, A_SPH, 8'h00, "R7 push carries to 100H");
    rd(A_SPH, "R8 high reads 01");
    step(1'b1, 2'd1, 1'b0, A_SPL, 8'h00, "R7 pop at 100H");
    wr(A_SPH, 8'hFF, "R8 high write FF");
    rd(A_SPH, "R8 high reads 07");
    wr(A_SPL, 8'hFF, "R7 preload 7FF");
    step(1'b1, 2'd0, 1'b0, A_SPL, 8'h00, "R7 push wraps to 000");
    step(1'b1, 2'd1, 1'b0, A_SPH, 8'h00, "R7 pop at 000");
    rd(A_SPH, "R7 pointer 7FF high");
    rd(A_SPL, "R7 pointer 7FF low");
    step(1'b1, 2'd2, 1'b0, A_SPL, 8'h00, "R4 call across wrap");
    step(1'b0, 2'd0, 1'b0, A_SPL, 8'h00, "R4 call high across wrap");
    step(1'b1, 2'd3, 1'b0, A_SPL, 8'h00, "R5 return across wrap");
    step(1'b0, 2'd0, 1'b0, A_SPL, 8'h00, "R5 return low across wrap");
    step(1'b1, 2'd0, 1'b1, A_SPL, 8'h40, "R10 low write with push");
    rd(A_SPL, "R10 low byte wins");
    step(1'b1, 2'd1, 1'b1, A_SPH, 8'h02, "R10 high write with pop");
    rd(A_SPH, "R10 high byte wins");
    rd(A_SPL, "R10 low after high write");
    wr(A_SPH, 8'h03, "R11 set upper bits");
    wr(A_CFG, 8'h00, "R11 ext off");
    rd(A_SPH, "R11 high reads 00");
    step(1'b1, 2'd0, 1'b0, A_SPL, 8'h00, "R11 push below 100H");
    wr(A_CFG, 8'h80, "R11 ext back on");
    rd(A_SPH, "R11 upper bits stayed clear");
    rd(8'h10, "R9 unmapped read");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule